// File: doc/BRIEF.md
# Receive DMA First-Error Offset Capture

This block sits beside a serial receive DMA channel that moves bytes from a small receive FIFO into a memory buffer. It watches each byte as it leaves the FIFO. Each byte carries its write offset within the buffer and two error tags, parity and framing. The block also watches an overflow pulse raised at the FIFO input. It records, in a read-only register, the buffer offset of the first byte that went wrong.

The first captured error locks the register. Later errors are ignored until software reloads the buffer or resets the receive DMA. An overflow is seen at the FIFO input, ahead of the DMA. Its offset is therefore corrected by the bytes still queued in the FIFO and then moved back by the FIFO lead depth of four bytes.

Top module: `rx_err_offset_capture`

## Requirements
- R1: After reset the 32-bit register reads 0x00000000. Bits 31 to 13 always read zero, and the captured offset sits in bits 12 to 0.
- R2: If nothing has been captured, a byte with `byte_wr` high and a parity or framing tag set stores `byte_ofs`. The stored value appears in bits 12 to 0 on the cycle after that clock edge.
- R3: If nothing has been captured, `ovf_pulse` stores `byte_ofs + fifo_occ - 4`, taken modulo 8192. When `byte_ofs + fifo_occ` is below 4, the stored value is 0.
- R4: While nothing has been captured, the register reads zero. Error tags presented with `byte_wr` low have no effect.
- R5: Once an error is captured, later parity, framing or overflow errors leave the register unchanged. This also holds when the capture was a genuine error at offset 0.
- R6: A clock edge with `buf_load` or `dma_reset` high clears the register to zero and re-arms capture.
- R7: A clear in the same cycle as an error wins. The register reads zero afterwards and capture stays armed.
- R8: If a tagged byte and an overflow arrive together with nothing captured, the smaller of the two offsets is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_wr | input | 1 | A byte leaves the FIFO this cycle |
| byte_ofs | input | 13 | Current buffer write offset |
| byte_par_err | input | 1 | Parity error tag of the byte |
| byte_frm_err | input | 1 | Framing error tag of the byte |
| ovf_pulse | input | 1 | Overflow at the FIFO input |
| fifo_occ | input | 3 | Bytes queued in the FIFO |
| buf_load | input | 1 | Buffer (re)load strobe |
| dma_reset | input | 1 | Receive DMA reset |
| err_reg | output | 32 | First-error offset register value |

## Verification
The block holds a hidden valid flag. A wrong flag shows at the ports in two ways. The first is a later error that overwrites a sticky value, which shows on the next cycle. The second is a capture that never happens, so the register stays at zero when an error was expected. A capture at offset 0 is the sharp case. Only a later error can reveal whether the flag was set, so the bench follows such captures with errors and checks that the register still reads zero. A wrong overflow correction or a wrong tie-break shows one cycle after the event, as a wrong value in bits 12 to 0.

// File: rtl/rx_err_offset_capture.sv
module rx_err_offset_capture #(
  parameter int OFS_W    = 13,
  parameter int REG_W    = 32,
  parameter int OCC_W    = 3,
  parameter int OVF_LEAD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_wr,
  input  logic [OFS_W-1:0] byte_ofs,
  input  logic             byte_par_err,
  input  logic             byte_frm_err,
  input  logic             ovf_pulse,
  input  logic [OCC_W-1:0] fifo_occ,
  input  logic             buf_load,
  input  logic             dma_reset,
  output logic [REG_W-1:0] err_reg
);
  localparam int SUM_W = ((OFS_W > OCC_W) ? OFS_W : OCC_W) + 1;

  logic             valid_q;
  logic [OFS_W-1:0] ofs_q;
  logic             clr, tag_hit;
  logic [SUM_W-1:0] ovf_sum;
  logic [OFS_W-1:0] ovf_ofs, pick_ofs;

  assign clr     = buf_load | dma_reset;
  assign tag_hit = byte_wr & (byte_par_err | byte_frm_err);
  assign ovf_sum = SUM_W'(byte_ofs) + SUM_W'(fifo_occ);
  assign ovf_ofs = (ovf_sum < SUM_W'(OVF_LEAD)) ? '0 : OFS_W'(ovf_sum - SUM_W'(OVF_LEAD));

  always_comb begin
    if (tag_hit && ovf_pulse) pick_ofs = (ovf_ofs < byte_ofs) ? ovf_ofs : byte_ofs;
    else if (ovf_pulse)       pick_ofs = ovf_ofs;
    else                      pick_ofs = byte_ofs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ofs_q   <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
      ofs_q   <= '0;
    end else if (!valid_q && (tag_hit || ovf_pulse)) begin
      valid_q <= 1'b1;
      ofs_q   <= pick_ofs;
    end
  end

  assign err_reg = {{(REG_W-OFS_W){1'b0}}, ofs_q};

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_reg == '0)); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr) |=> $stable(err_reg)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !clr && !tag_hit && !ovf_pulse) |=> (err_reg == '0)); // R4
  AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !clr && tag_hit && !ovf_pulse) |=> (err_reg[OFS_W-1:0] == $past(byte_ofs))); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (tag_hit || ovf_pulse)) |=> !valid_q); // R7
endmodule

// File: tb/rx_err_offset_capture_tb.sv
module rx_err_offset_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_wr = 0, byte_par_err = 0, byte_frm_err = 0, ovf_pulse = 0, buf_load = 0, dma_reset = 0;
  logic [12:0] byte_ofs = '0;
  logic [2:0]  fifo_occ = '0;
  logic [31:0] err_reg;

  int n_chk = 0, n_bad = 0;
  bit          m_valid = 0;
  logic [12:0] m_ofs = '0;

  always #4 clk = ~clk;

  rx_err_offset_capture dut_i (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_ofs(byte_ofs),
    .byte_par_err(byte_par_err), .byte_frm_err(byte_frm_err), .ovf_pulse(ovf_pulse),
    .fifo_occ(fifo_occ), .buf_load(buf_load), .dma_reset(dma_reset), .err_reg(err_reg));

  function automatic logic [12:0] ovf_offset(logic [12:0] o, logic [2:0] q);
    int s = int'(o) + int'(q);
    return (s < 4) ? 13'd0 : 13'((s - 4) % 8192);
  endfunction

  function automatic logic [12:0] min13(logic [12:0] a, logic [12:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(string req);
    logic [31:0] exp = {19'd0, m_ofs};
    n_chk++;
    if (err_reg !== exp) begin
      n_bad++;
      $display("FAIL %s: err_reg=%08h expected=%08h", req, err_reg, exp);
    end
  endtask

  task automatic step(bit wr, logic [12:0] ofs, bit par, bit frm, bit ovf, logic [2:0] occ,
                      bit ld, bit dr, string req);
    bit tag;
    byte_wr = wr; byte_ofs = ofs; byte_par_err = par; byte_frm_err = frm;
    ovf_pulse = ovf; fifo_occ = occ; buf_load = ld; dma_reset = dr;
    tag = wr && (par || frm);
    @(posedge clk);
    if (ld || dr) begin
      m_valid = 0; m_ofs = '0;
    end else if (!m_valid && (tag || ovf)) begin
      m_valid = 1;
      if (tag && ovf) m_ofs = min13(ofs, ovf_offset(ofs, occ));
      else if (ovf)   m_ofs = ovf_offset(ofs, occ);
      else            m_ofs = ofs;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
    step(0, 13'd77, 1, 1, 0, 3'd0, 0, 0, "R4 tags without byte_wr");
    step(1, 13'd90, 0, 0, 0, 3'd2, 0, 0, "R4 clean byte");
    step(1, 13'd300, 1, 0, 0, 3'd0, 0, 0, "R2 parity capture");
    step(1, 13'd301, 0, 1, 0, 3'd0, 0, 0, "R5 later framing");
    step(0, 13'd302, 0, 0, 1, 3'd5, 0, 0, "R5 later overflow");
    step(0, 13'd0, 0, 0, 0, 3'd0, 1, 0, "R6 buffer load clears");
    step(0, 13'd100, 0, 0, 1, 3'd3, 0, 0, "R3 overflow correction");
    step(0, 13'd0, 0, 0, 0, 3'd0, 0, 1, "R6 dma reset clears");
    step(0, 13'd1, 0, 0, 1, 3'd2, 0, 0, "R3 saturation at zero");
    step(1, 13'd50, 1, 0, 0, 3'd0, 0, 0, "R5 after offset-0 capture");
    step(0, 13'd60, 0, 0, 1, 3'd7, 0, 0, "R5 after offset-0 capture ovf");
    step(1, 13'd500, 0, 1, 0, 3'd0, 1, 0, "R7 clear beats capture");
    step(1, 13'd400, 1, 0, 0, 3'd0, 0, 0, "R7 still armed");
    step(0, 13'd0, 0, 0, 0, 3'd0, 0, 1, "R6 clear");
    step(1, 13'd20, 1, 0, 1, 3'd7, 0, 0, "R8 byte smaller");
    step(0, 13'd0, 0, 0, 0, 3'd0, 1, 0, "R6 clear");
    step(1, 13'd20, 0, 1, 1, 3'd1, 0, 0, "R8 overflow smaller");
    step(0, 13'd0, 0, 0, 0, 3'd0, 1, 0, "R6 clear");
    step(0, 13'd8190, 0, 0, 1, 3'd7, 0, 0, "R3 modulo wrap");
    step(0, 13'd0, 0, 0, 0, 3'd0, 1, 1, "R6 both clears");
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      step(($urandom_range(0, 3) != 0), 13'($urandom), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 19) == 0), 3'($urandom),
           (r < 4), (r >= 97), "R2 R3 R5 R6 R8 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule